// File: doc/BRIEF.md
# Framed Direct-Sequence Spreading Transmitter

This block turns 4-bit data nibbles into one serial chip stream for a direct-sequence spread-spectrum link. It protects each nibble with a single-error-correcting (7,4) Hamming code. The first codeword of a transmit session goes out behind a fixed preamble and an all-zero coded sync frame, so that a receiver can find chip phase and then frame phase. Each coded bit then lasts 31 chips. Every chip is the coded bit XOR one chip of a length-31 maximal-length pseudo-noise sequence, and that sequence restarts at the start of every bit.

The chip clock runs 31 times faster than the bit rate. Both rates are modelled on one clock: a chip counter inside the block marks the end of each bit period. A source holds `tx_enable` high for a session and raises `nib_valid` with a nibble. The block takes the nibble when it is idle, and `busy` stays high for exactly as long as the resulting chips are on `chip_out`.

Top module: `dsss_spreader_tx`

## Requirements
- R1: While `busy` is low, `chip_out` is 0. After reset, `busy` is low.
- R2: A nibble is taken at a clock edge only if, at that edge, `busy` is low and both `tx_enable` and `nib_valid` are high. `busy` is high from the next cycle. With either input low, nothing starts.
- R3: The first codeword of a session is preceded by a preamble of ten 1 bits followed by one 0 bit.
- R4: Between the preamble and the first data codeword comes a sync frame of seven 0 bits (nibble 0000 with check bits 000).
- R5: A codeword is sent as d3, d2, d1, d0, then p2, p1, p0, where p2 = d3^d2^d1, p1 = d3^d2^d0 and p0 = d3^d1^d0. So nibble 0010 carries checks 101 and nibble 0100 carries checks 110.
- R6: Each bit occupies 31 consecutive chips, with chip k = bit XOR pn[k]. Here pn[0..4] = 0,0,0,0,1 and pn[n] = pn[n-5] XOR pn[n-3], the sequence of x^5+x^2+1 from seed 00001. The sequence restarts at k = 0 for every bit.
- R7: `busy` stays high without a gap for 25*31 = 775 chips when the preamble and sync frame are included, or 7*31 = 217 chips otherwise. It falls right after the last chip.
- R8: `nib_valid` pulses that arrive while `busy` is high are ignored: no extra bits are sent and the current burst is not changed.
- R9: A session ends when `tx_enable` is low on a clock edge while the block is idle. While `tx_enable` stays high, later nibbles are sent without preamble or sync frame. The first nibble of a new session gets both again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Chip-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_enable | input | 1 | Session enable from the source |
| nib_valid | input | 1 | Nibble on `nib_data` is offered |
| nib_data | input | 4 | Data nibble, bit 3 sent first |
| chip_out | output | 1 | Spread chip stream |
| busy | output | 1 | High while chips of a burst are being sent |

## Verification
A nibble taken at edge t shows its first chip in the cycle after t. Bit j of the burst occupies cycles t+1+31j to t+31(j+1), and `busy` falls at edge t+31N, where N is 25 or 7. The monitor samples on the falling clock edge. It keeps a chip index that starts when `busy` rises and wraps every 31 chips. After each 31 chips it despreads them with its own copy of the sequence. It then compares the recovered bit with the next bit in the expected queue, and it also requires all 31 chips to agree. When `busy` falls, the monitor checks the burst length against the length the driver queued and checks that the last bit was complete. Tests where nothing should start check `busy` at every sample in a window of cycles.

// File: rtl/dsss_pkg.sv
package dsss_pkg;
  localparam int PN_W      = 5;
  localparam int CHIPS     = (1 << PN_W) - 1;
  localparam int NIB_W     = 4;
  localparam int CHK_W     = 3;
  localparam int CW_LEN    = NIB_W + CHK_W;
  localparam int SYNC_LEN  = CW_LEN;

  // Check bits {p2,p1,p0} of the (7,4) code.
  function automatic logic [CHK_W-1:0] ham_checks(input logic [NIB_W-1:0] d);
    ham_checks[2] = d[3] ^ d[2] ^ d[1];
    ham_checks[1] = d[3] ^ d[2] ^ d[0];
    ham_checks[0] = d[3] ^ d[1] ^ d[0];
  endfunction

  // Codeword, first-sent bit in the MSB.
  function automatic logic [CW_LEN-1:0] ham_codeword(input logic [NIB_W-1:0] d);
    ham_codeword = {d, ham_checks(d)};
  endfunction

  // One step of the x^5+x^2+1 generator; output chip is state[4].
  function automatic logic [PN_W-1:0] pn_advance(input logic [PN_W-1:0] s);
    pn_advance = {s[3:0], s[4] ^ s[2]};
  endfunction
endpackage

// File: rtl/dsss_chip_timer.sv
module dsss_chip_timer #(
  parameter int CHIPS = 31
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     run,
  output logic [$clog2(CHIPS)-1:0] chip_idx,
  output logic                     bit_end
);
  localparam int IW = $clog2(CHIPS);
  localparam logic [IW-1:0] LAST = IW'(CHIPS - 1);

  assign bit_end = run && (chip_idx == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n)        chip_idx <= '0;
    else if (start)    chip_idx <= '0;
    else if (bit_end)  chip_idx <= '0;
    else if (run)      chip_idx <= chip_idx + 1'b1;
  end
endmodule

// File: rtl/dsss_pn_gen.sv
module dsss_pn_gen
  import dsss_pkg::*;
#(
  parameter logic [PN_W-1:0] SEED = 5'b00001
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            restart,
  input  logic            advance,
  output logic [PN_W-1:0] pn_state,
  output logic            pn_chip
);
  assign pn_chip = pn_state[PN_W-1];

  always_ff @(posedge clk) begin
    if (!rst_n)        pn_state <= SEED;
    else if (restart)  pn_state <= SEED;
    else if (advance)  pn_state <= pn_advance(pn_state);
  end
endmodule

// File: rtl/dsss_frame_shifter.sv
module dsss_frame_shifter #(
  parameter int LEN = 25
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     load,
  input  logic [LEN-1:0]           load_vec,
  input  logic [$clog2(LEN+1)-1:0] load_bits,
  input  logic                     shift,
  output logic [LEN-1:0]           frame_q,
  output logic                     cur_bit,
  output logic                     last_bit
);
  localparam int CW = $clog2(LEN + 1);
  logic [CW-1:0] bits_left;

  assign cur_bit  = frame_q[LEN-1];
  assign last_bit = (bits_left == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      frame_q   <= '0;
      bits_left <= '0;
    end else if (load) begin
      frame_q   <= load_vec;
      bits_left <= load_bits;
    end else if (shift) begin
      frame_q   <= {frame_q[LEN-2:0], 1'b0};
      bits_left <= bits_left - 1'b1;
    end
  end
endmodule

// File: rtl/dsss_spreader_tx.sv
module dsss_spreader_tx
  import dsss_pkg::*;
#(
  parameter int                HDR_ONES = 10,
  parameter logic [PN_W-1:0]   PN_SEED  = 5'b00001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_enable,
  input  logic             nib_valid,
  input  logic [NIB_W-1:0] nib_data,
  output logic             chip_out,
  output logic             busy
);
  localparam int HDR_LEN   = HDR_ONES + 1;
  localparam int FRAME_LEN = HDR_LEN + SYNC_LEN + CW_LEN;
  localparam int BW        = $clog2(FRAME_LEN + 1);
  localparam int IW        = $clog2(CHIPS);
  localparam logic [HDR_LEN-1:0]  HDR_VEC  = {{HDR_ONES{1'b1}}, 1'b0};
  localparam logic [SYNC_LEN-1:0] SYNC_VEC = ham_codeword('0);

  // Named internal events
  logic                 accept;
  logic                 bit_end;
  logic                 last_bit;
  logic                 cur_bit;
  logic                 pn_chip;
  logic [PN_W-1:0]      pn_state;
  logic [IW-1:0]        chip_idx;
  logic [FRAME_LEN-1:0] frame_q;
  logic                 busy_q;
  logic                 framed_q;
  logic [FRAME_LEN-1:0] load_vec;
  logic [BW-1:0]        load_bits;

  assign accept = !busy_q && tx_enable && nib_valid;

  always_comb begin
    if (framed_q) begin
      load_vec  = {ham_codeword(nib_data), {(FRAME_LEN - CW_LEN){1'b0}}};
      load_bits = BW'(CW_LEN);
    end else begin
      load_vec  = {HDR_VEC, SYNC_VEC, ham_codeword(nib_data)};
      load_bits = BW'(FRAME_LEN);
    end
  end

  dsss_chip_timer #(.CHIPS(CHIPS)) i_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (accept),
    .run      (busy_q),
    .chip_idx (chip_idx),
    .bit_end  (bit_end)
  );

  dsss_pn_gen #(.SEED(PN_SEED)) i_pn (
    .clk      (clk),
    .rst_n    (rst_n),
    .restart  (accept || bit_end),
    .advance  (busy_q),
    .pn_state (pn_state),
    .pn_chip  (pn_chip)
  );

  dsss_frame_shifter #(.LEN(FRAME_LEN)) i_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_vec  (load_vec),
    .load_bits (load_bits),
    .shift     (bit_end),
    .frame_q   (frame_q),
    .cur_bit   (cur_bit),
    .last_bit  (last_bit)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      framed_q <= 1'b0;
    end else begin
      if (accept)                    busy_q <= 1'b1;
      else if (bit_end && last_bit)  busy_q <= 1'b0;
      if (accept)                    framed_q <= 1'b1;
      else if (!busy_q && !tx_enable) framed_q <= 1'b0;
    end
  end

  assign busy     = busy_q;
  assign chip_out = busy_q & (cur_bit ^ pn_chip);
endmodule

// File: rtl/dsss_spreader_tx_chk.sv
module dsss_spreader_tx_chk
  import dsss_pkg::*;
#(
  parameter int              FRAME_LEN = 25,
  parameter logic [PN_W-1:0] PN_SEED   = 5'b00001
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      accept,
  input logic                      bit_end,
  input logic                      last_bit,
  input logic                      busy,
  input logic                      chip_out,
  input logic                      tx_enable,
  input logic                      nib_valid,
  input logic [PN_W-1:0]           pn_state,
  input logic [$clog2(CHIPS)-1:0]  chip_idx,
  input logic [FRAME_LEN-1:0]      frame_q
);
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !chip_out);

  assert_start_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && tx_enable && nib_valid) |=> busy);

  assert_no_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(tx_enable && nib_valid)) |=> !busy);

  assert_pn_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (accept || bit_end) |=> (pn_state == PN_SEED && chip_idx == '0));

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(bit_end && last_bit)) |=> busy);

  assert_busy_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (bit_end && last_bit) |=> !busy);

  assert_ignore_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !bit_end) |=> $stable(frame_q));
endmodule

bind dsss_spreader_tx dsss_spreader_tx_chk #(
  .FRAME_LEN (FRAME_LEN),
  .PN_SEED   (PN_SEED)
) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .accept    (accept),
  .bit_end   (bit_end),
  .last_bit  (last_bit),
  .busy      (busy),
  .chip_out  (chip_out),
  .tx_enable (tx_enable),
  .nib_valid (nib_valid),
  .pn_state  (pn_state),
  .chip_idx  (chip_idx),
  .frame_q   (frame_q)
);

// File: tb/test_dsss_spreader_tx.sv
`timescale 1ns/1ps
module test_dsss_spreader_tx;
  localparam int NCHIP = 31;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tx_enable = 1'b0;
  logic       nib_valid = 1'b0;
  logic [3:0] nib_data = '0;
  logic       chip_out;
  logic       busy;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  bit    pn_ref [NCHIP];
  bit    exp_bits[$];
  string exp_tags[$];
  int    exp_len[$];
  bit    sess_open = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  dsss_spreader_tx i_dsss_spreader_tx (
    .clk(clk), .rst_n(rst_n), .tx_enable(tx_enable), .nib_valid(nib_valid),
    .nib_data(nib_data), .chip_out(chip_out), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Check bits restated as XOR of code columns (d3,d2,d1,d0 -> 111,110,101,011).
  function automatic logic [2:0] ref_checks(input logic [3:0] d);
    logic [2:0] col [4];
    col[3] = 3'b111; col[2] = 3'b110; col[1] = 3'b101; col[0] = 3'b011;
    ref_checks = '0;
    for (int i = 0; i < 4; i++) if (d[i]) ref_checks ^= col[i];
  endfunction

  task automatic push_bit(input bit b, input string tag);
    exp_bits.push_back(b);
    exp_tags.push_back(tag);
  endtask

  // Driver: offer one nibble when idle and queue what should come out.
  task automatic send_nibble(input logic [3:0] d);
    logic [6:0] cw;
    while (busy) @(negedge clk);
    tx_enable = 1'b1;
    nib_valid = 1'b1;
    nib_data  = d;
    if (!sess_open) begin
      for (int i = 0; i < 10; i++) push_bit(1'b1, "R3");
      push_bit(1'b0, "R3");
      for (int i = 0; i < 7; i++) push_bit(1'b0, "R4");
      exp_len.push_back(25 * NCHIP);
      sess_open = 1'b1;
    end else begin
      exp_len.push_back(7 * NCHIP);
    end
    cw = {d, ref_checks(d)};
    if (d == 4'b0010) cw = 7'b0010101;  // R5 literal case
    if (d == 4'b0100) cw = 7'b0100110;  // R5 literal case
    for (int i = 6; i >= 0; i--) push_bit(cw[i], "R5");
    @(negedge clk);
    nib_valid = 1'b0;
  endtask

  task automatic end_session();
    while (busy) @(negedge clk);
    tx_enable = 1'b0;
    repeat (2) @(negedge clk);
    sess_open = 1'b0;
  endtask

  task automatic wait_idle();
    while (busy || exp_bits.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  // Hold inputs for n cycles and require no start (R2).
  task automatic quiet_window(input int n, input bit en, input bit vld);
    int seen = 0;
    tx_enable = en;
    nib_valid = vld;
    nib_data  = 4'hA;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (busy || chip_out) seen++;
    end
    nib_valid = 1'b0;
    check(seen == 0, "R2", "start with gated inputs", seen, 0);
  endtask

  // Monitor: despread 31 chips per bit and compare with the queue.
  int  idx = 0;
  int  votes = 0;
  int  burst = 0;
  bit  prev_busy = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (busy) begin
        votes += int'(chip_out ^ pn_ref[idx]);
        burst++;
        if (idx == NCHIP - 1) begin
          check(votes == 0 || votes == NCHIP, "R6", "chip agreement in bit",
                votes, (votes > NCHIP / 2) ? NCHIP : 0);
          if (exp_bits.size() == 0) begin
            check(1'b0, "R8", "unexpected bit", votes > NCHIP / 2, -1);
          end else begin
            bit    eb;
            string et;
            eb = exp_bits.pop_front();
            et = exp_tags.pop_front();
            check((votes > NCHIP / 2) == eb, et, "despread bit",
                  int'(votes > NCHIP / 2), int'(eb));
          end
          idx = 0;
          votes = 0;
        end else begin
          idx++;
        end
      end else begin
        if (prev_busy) begin
          check(idx == 0, "R6", "partial bit at burst end", idx, 0);
          check(chip_out == 1'b0, "R1", "chip_out while idle", chip_out, 0);
          if (exp_len.size() == 0)
            check(1'b0, "R8", "unexpected burst", burst, 0);
          else begin
            int el;
            el = exp_len.pop_front();
            check(burst == el, "R7", "busy length", burst, el);
          end
        end
        burst = 0;
        idx = 0;
        votes = 0;
      end
      prev_busy = busy;
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      done = 1'b1;
      check(1'b0, "WDOG", "watchdog expired", cycles, 150000);
      finish_run();
    end
  end

  initial begin
    for (int i = 0; i < 5; i++) pn_ref[i] = (i == 4);
    for (int i = 5; i < NCHIP; i++) pn_ref[i] = pn_ref[i-5] ^ pn_ref[i-3];

    repeat (4) @(negedge clk);
    check(busy == 1'b0, "R1", "busy after reset", busy, 0);
    check(chip_out == 1'b0, "R1", "chip_out after reset", chip_out, 0);
    rst_n = 1'b1;
    @(negedge clk);

    quiet_window(40, 1'b0, 1'b1);   // R2: enable low
    quiet_window(40, 1'b1, 1'b0);   // R2: valid low
    tx_enable = 1'b0;
    @(negedge clk);

    // R3/R4/R5: first session with the literal check cases
    send_nibble(4'b0010);
    send_nibble(4'b0100);
    // R8: offer another nibble in the middle of a burst
    send_nibble(4'h9);
    repeat (50) @(negedge clk);
    nib_data = 4'h6;
    nib_valid = 1'b1;
    repeat (3) @(negedge clk);
    nib_valid = 1'b0;
    wait_idle();
    check(exp_len.size() == 0, "R8", "burst count after ignored pulse",
          exp_len.size(), 0);

    // R9: new session gets preamble again; all nibble values
    end_session();
    for (int v = 0; v < 16; v++) send_nibble(4'(v));
    wait_idle();
    end_session();
    send_nibble(4'hF);
    send_nibble(4'h0);
    wait_idle();
    tx_enable = 1'b0;
    repeat (5) @(negedge clk);

    check(exp_bits.size() == 0, "R9", "leftover expected bits", exp_bits.size(), 0);
    check(busy == 1'b0 && chip_out == 1'b0, "R1", "final idle", busy, 0);
    done = 1'b1;
    finish_run();
  end
endmodule